// File: doc/BRIEF.md
# USB 2.0 PHY Port Control Register Bank

This block is the small register file that sits beside one USB 2.0 PHY port pair. The port pair is an on-the-go port and a host port. Software writes control fields over a 32-bit register bus: the two suspend codes, the ID pull-up, the two clock-output keep bits, and the charger-detect enable and reset for each port. Every write carries its own per-bit write mask in the upper half-word. This lets one field be changed without a read-modify-write sequence. A data bit in 15:0 changes only when the bit 16 places above it is 1. For example, writing `0x0200_0200` sets bit 9 and leaves every other bit as it was.

The raw PHY status lines arrive asynchronously: bus-valid, ID, both disconnect detectors, both line-state signals and the four charger-detect results. Each line passes through a two-flop synchronizer. The synchronized levels can be read as one status word. The bank also turns edges on these lines into ten sticky event bits. Each event has its own enable bit, status bit and write-1-to-clear bit. A single registered interrupt output is raised while any enabled event is pending.

Top module: `usbphy_ctl_bank`

Register map (byte addresses, word aligned):

| Address | Access | Layout |
|---|---|---|
| 0x00 | RW | OTG suspend code [8:0], reset `0x1D9`; ID pull-up [9]; OTG clock keep [10] |
| 0x04 | RW | host suspend code [3:0], reset `0x9`; host clock keep [4] |
| 0x08 | RW | OTG charger enable [0]; OTG charger reset [1], reset 1; host charger enable [2]; host charger reset [3], reset 1 |
| 0x0C | RO | synchronized levels |
| 0x10 | RW | event enable [9:0] |
| 0x14 | RO | event status [9:0] |
| 0x18 | W1C | event clear [9:0], reads 0 |
| 0x1C | — | unmapped, reads 0 |

## Requirements
- R1: After a synchronous reset, the registers read as follows: 0x00 reads `0x000001D9`, 0x04 reads `0x00000009`, 0x08 reads `0x0000000A`, and the enable and status registers read 0. `irq_o` is 0.
- R2: A write to a RW register updates data bit i (i in 0..15) only when bit i+16 of the write data is 1. Other bits keep their value. Bits outside the register's implemented fields always read 0.
- R3: Each control output equals its field in the register map. The fields are `otg_sus_o`=0x00[8:0], `id_pullup_o`=0x00[9], `otg_clk_keep_o`=0x00[10], `host_sus_o`=0x04[3:0], `host_clk_keep_o`=0x04[4], and `otg_chg_en_o`, `otg_chg_rst_o`, `host_chg_en_o`, `host_chg_rst_o`=0x08[0..3]. Software uses the codes `0x1D9`/`0x052` and `0x9`/`0x2` for suspended/running.
- R4: The status word at 0x0C shows the synchronized inputs at these bit positions: bus-valid at bit 9, ID at bit 6, OTG disconnect at bit 7, host disconnect at bit 23, OTG charger valid/connect at bits 12/13, and host charger valid/connect at bits 28/29. All other bits are 0.
- R5: The event bit map is as follows: 0 is any change of OTG line state and 1 is any change of host line state. Bits 2 and 3 are bus-valid rise and fall, and bits 4 and 5 are ID rise and fall. Bits 6 and 7 are OTG disconnect rise and fall, and bits 8 and 9 are host disconnect rise and fall. The enable, status and clear registers all use this bit map.
- R6: An edge sets its status bit only while its enable bit is 1. An edge that arrives while disabled leaves status at 0.
- R7: A status bit stays set until cleared. Writing 1 to a clear bit with its mask bit set clears it. A clear bit written without its mask, or any write to the status register, has no effect. The clear register reads 0.
- R8: When a clear of a bit and a new edge for that bit fall in the same cycle, the clear wins and the status bit reads 0.
- R9: `irq_o` is the registered OR of (status AND enable). Clearing the enable drops `irq_o` on the next cycle but keeps the status bit.
- R10: An input change applied before clock edge 1 sets the status bit at edge 3. `irq_o` rises at edge 4.
- R11: `bus_rdata` is registered. It shows the register addressed during the previous cycle, and an unmapped word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| bus_wr | input | 1 | write strobe for one cycle |
| bus_addr | input | ADDR_W | byte address |
| bus_wdata | input | 32 | write mask [31:16] and data [15:0] |
| bus_rdata | output | 32 | registered read data |
| phy_bvalid | input | 1 | bus-valid level, asynchronous |
| phy_iddig | input | 1 | ID level, asynchronous |
| phy_otg_discon | input | 1 | OTG disconnect detector |
| phy_host_discon | input | 1 | host disconnect detector |
| phy_otg_ls | input | 1 | OTG line-state signal |
| phy_host_ls | input | 1 | host line-state signal |
| phy_otg_chg_valid | input | 1 | OTG charger valid |
| phy_otg_chg_conn | input | 1 | OTG charger connect |
| phy_host_chg_valid | input | 1 | host charger valid |
| phy_host_chg_conn | input | 1 | host charger connect |
| otg_sus_o | output | 9 | OTG suspend code |
| host_sus_o | output | 4 | host suspend code |
| id_pullup_o | output | 1 | ID pull-up select |
| otg_clk_keep_o | output | 1 | keep OTG clock output running |
| host_clk_keep_o | output | 1 | keep host clock output running |
| otg_chg_en_o | output | 1 | OTG charger detector enable |
| otg_chg_rst_o | output | 1 | OTG charger detector reset |
| host_chg_en_o | output | 1 | host charger detector enable |
| host_chg_rst_o | output | 1 | host charger detector reset |
| irq_o | output | 1 | combined event interrupt |

## Verification
The bench sweeps random masked writes over all three control registers and predicts each readback and control output. This catches a design that applies the mask to the wrong half or leaks unimplemented bits. It walks all 256 combinations of the eight level inputs through the status word, so a swapped bit position shows up at once. For each of the ten events it checks the exact cycles of the status and interrupt rise. It also checks that a clear without a mask does nothing. A design that counted synchronizer stages wrongly would raise the interrupt one cycle off. The bench forces a clear and a fresh edge into the same cycle: a design that let the edge win would show a pending bit. It also checks that dropping an enable silences the interrupt without losing the pending status.

// File: rtl/usbphy_bank_pkg.sv
package usbphy_bank_pkg;
  localparam int BUS_W  = 32;
  localparam int HALF_W = BUS_W / 2;
  localparam int N_EVT  = 10;
  localparam int N_RAW  = 10;

  // word indices inside the bank
  localparam int WI_OTG_CTRL  = 0;
  localparam int WI_HOST_CTRL = 1;
  localparam int WI_CHG_CTRL  = 2;
  localparam int WI_LEVELS    = 3;
  localparam int WI_EVT_EN    = 4;
  localparam int WI_EVT_STS   = 5;
  localparam int WI_EVT_CLR   = 6;

  // raw input order on the synchronizer vector
  localparam int RI_BVALID   = 0;
  localparam int RI_IDDIG    = 1;
  localparam int RI_OTG_DIS  = 2;
  localparam int RI_HOST_DIS = 3;
  localparam int RI_OTG_LS   = 4;
  localparam int RI_HOST_LS  = 5;
  localparam int RI_OTG_CV   = 6;
  localparam int RI_OTG_CC   = 7;
  localparam int RI_HOST_CV  = 8;
  localparam int RI_HOST_CC  = 9;

  // event bit positions (shared by enable, status, clear)
  localparam int EV_OTG_LS    = 0;
  localparam int EV_HOST_LS   = 1;
  localparam int EV_BV_RISE   = 2;
  localparam int EV_BV_FALL   = 3;
  localparam int EV_ID_RISE   = 4;
  localparam int EV_ID_FALL   = 5;
  localparam int EV_ODIS_RISE = 6;
  localparam int EV_ODIS_FALL = 7;
  localparam int EV_HDIS_RISE = 8;
  localparam int EV_HDIS_FALL = 9;

  // level word bit positions
  localparam int LB_BVALID   = 9;
  localparam int LB_IDDIG    = 6;
  localparam int LB_OTG_DIS  = 7;
  localparam int LB_OTG_CV   = 12;
  localparam int LB_OTG_CC   = 13;
  localparam int LB_HOST_DIS = 23;
  localparam int LB_HOST_CV  = 28;
  localparam int LB_HOST_CC  = 29;

  // control field layout
  localparam int OTG_SUS_W  = 9;
  localparam int HOST_SUS_W = 4;
  localparam int OC_PULLUP  = 9;
  localparam int OC_CLKKEEP = 10;
  localparam int HC_CLKKEEP = 4;
  localparam int CC_OTG_EN  = 0;
  localparam int CC_OTG_RST = 1;
  localparam int CC_HST_EN  = 2;
  localparam int CC_HST_RST = 3;

  localparam logic [HALF_W-1:0] IMPL_OTG  = 16'h07FF;
  localparam logic [HALF_W-1:0] IMPL_HOST = 16'h001F;
  localparam logic [HALF_W-1:0] IMPL_CHG  = 16'h000F;
  localparam logic [HALF_W-1:0] IMPL_EVT  = HALF_W'((1 << N_EVT) - 1);
endpackage

// File: rtl/usbphy_sync.sv
module usbphy_sync #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o,
  output logic [N-1:0] prev_o
);
  logic [N-1:0] meta_q;
  logic [N-1:0] sync_q;
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q[i] <= 1'b0;
        sync_q[i] <= 1'b0;
        prev_q[i] <= 1'b0;
      end else begin
        meta_q[i] <= async_i[i];
        sync_q[i] <= meta_q[i];
        prev_q[i] <= sync_q[i];
      end
    end
  end

  assign sync_o = sync_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/usbphy_mreg.sv
module usbphy_mreg #(
  parameter int                 HALF_W = 16,
  parameter logic [HALF_W-1:0]  IMPL   = '1,
  parameter logic [HALF_W-1:0]  RST    = '0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_i,
  input  logic [2*HALF_W-1:0]   wdata_i,
  output logic [HALF_W-1:0]     q_o
);
  logic [HALF_W-1:0] q;
  logic [HALF_W-1:0] wmask;
  logic [HALF_W-1:0] wval;

  assign wmask = wdata_i[2*HALF_W-1:HALF_W];
  assign wval  = wdata_i[HALF_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RST & IMPL;
    end else if (wr_i) begin
      q <= ((q & ~wmask) | (wval & wmask)) & IMPL;
    end
  end

  assign q_o = q;

  // R2: no write strobe, no change
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> $stable(q));

  // R2: a write with an empty mask leaves the register untouched
  p_nomask_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_i && (wmask == '0)) |=> $stable(q));

  // R2: unimplemented bits stay zero
  p_impl_r2: assert property (@(posedge clk) disable iff (rst)
    (q & ~IMPL) == '0);
endmodule

// File: rtl/usbphy_evt_bank.sv
module usbphy_evt_bank #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] sts_o,
  output logic         irq_o
);
  logic [N-1:0] sts_q;
  logic [N-1:0] sts_d;
  logic         irq_q;

  always_comb begin
    sts_d = (sts_q | (evt_i & en_i)) & ~clr_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= '0;
      irq_q <= 1'b0;
    end else begin
      sts_q <= sts_d;
      irq_q <= |(sts_q & en_i);
    end
  end

  assign sts_o = sts_q;
  assign irq_o = irq_q;

  // R8: a cleared bit reads zero next cycle even if an edge arrived
  p_clr_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (clr_i != '0) |=> ((sts_q & $past(clr_i)) == '0));

  // R7: pending bits that were not cleared remain pending
  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((sts_q & $past(sts_q & ~clr_i)) == $past(sts_q & ~clr_i)));

  // R6: no bit becomes pending while its enable was low
  p_needs_en_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(en_i)) == '0));

  // R9: nothing enabled and pending means interrupt low next cycle
  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    ((sts_q & en_i) == '0) |=> !irq_o);
endmodule

// File: rtl/usbphy_ctl_bank.sv
module usbphy_ctl_bank
  import usbphy_bank_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [BUS_W-1:0]      bus_wdata,
  output logic [BUS_W-1:0]      bus_rdata,
  input  logic                  phy_bvalid,
  input  logic                  phy_iddig,
  input  logic                  phy_otg_discon,
  input  logic                  phy_host_discon,
  input  logic                  phy_otg_ls,
  input  logic                  phy_host_ls,
  input  logic                  phy_otg_chg_valid,
  input  logic                  phy_otg_chg_conn,
  input  logic                  phy_host_chg_valid,
  input  logic                  phy_host_chg_conn,
  output logic [OTG_SUS_W-1:0]  otg_sus_o,
  output logic [HOST_SUS_W-1:0] host_sus_o,
  output logic                  id_pullup_o,
  output logic                  otg_clk_keep_o,
  output logic                  host_clk_keep_o,
  output logic                  otg_chg_en_o,
  output logic                  otg_chg_rst_o,
  output logic                  host_chg_en_o,
  output logic                  host_chg_rst_o,
  output logic                  irq_o
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [HALF_W-1:0] RST_OTG  = 16'h01D9;
  localparam logic [HALF_W-1:0] RST_HOST = 16'h0009;
  localparam logic [HALF_W-1:0] RST_CHG  = 16'h000A;

  logic [WORD_W-1:0] word;
  logic              unused_addr_lsb;
  logic              unused_wdata_hi;

  assign word            = bus_addr[ADDR_W-1:2];
  assign unused_addr_lsb = ^bus_addr[1:0];

  function automatic logic hit(input logic [WORD_W-1:0] w, input int idx);
    return w == WORD_W'(idx);
  endfunction

  logic wr_otg, wr_host, wr_chg, wr_en, wr_clr;
  assign wr_otg  = bus_wr && hit(word, WI_OTG_CTRL);
  assign wr_host = bus_wr && hit(word, WI_HOST_CTRL);
  assign wr_chg  = bus_wr && hit(word, WI_CHG_CTRL);
  assign wr_en   = bus_wr && hit(word, WI_EVT_EN);
  assign wr_clr  = bus_wr && hit(word, WI_EVT_CLR);

  // control and enable registers
  logic [HALF_W-1:0] otg_q, host_q, chg_q, en_q;

  usbphy_mreg #(.HALF_W(HALF_W), .IMPL(IMPL_OTG), .RST(RST_OTG)) u_otg (
    .clk(clk), .rst(rst), .wr_i(wr_otg), .wdata_i(bus_wdata), .q_o(otg_q));
  usbphy_mreg #(.HALF_W(HALF_W), .IMPL(IMPL_HOST), .RST(RST_HOST)) u_host (
    .clk(clk), .rst(rst), .wr_i(wr_host), .wdata_i(bus_wdata), .q_o(host_q));
  usbphy_mreg #(.HALF_W(HALF_W), .IMPL(IMPL_CHG), .RST(RST_CHG)) u_chg (
    .clk(clk), .rst(rst), .wr_i(wr_chg), .wdata_i(bus_wdata), .q_o(chg_q));
  usbphy_mreg #(.HALF_W(HALF_W), .IMPL(IMPL_EVT), .RST('0)) u_en (
    .clk(clk), .rst(rst), .wr_i(wr_en), .wdata_i(bus_wdata), .q_o(en_q));

  assign otg_sus_o       = otg_q[OTG_SUS_W-1:0];
  assign id_pullup_o     = otg_q[OC_PULLUP];
  assign otg_clk_keep_o  = otg_q[OC_CLKKEEP];
  assign host_sus_o      = host_q[HOST_SUS_W-1:0];
  assign host_clk_keep_o = host_q[HC_CLKKEEP];
  assign otg_chg_en_o    = chg_q[CC_OTG_EN];
  assign otg_chg_rst_o   = chg_q[CC_OTG_RST];
  assign host_chg_en_o   = chg_q[CC_HST_EN];
  assign host_chg_rst_o  = chg_q[CC_HST_RST];

  // input synchronization
  logic [N_RAW-1:0] raw, lvl, prv;
  always_comb begin
    raw              = '0;
    raw[RI_BVALID]   = phy_bvalid;
    raw[RI_IDDIG]    = phy_iddig;
    raw[RI_OTG_DIS]  = phy_otg_discon;
    raw[RI_HOST_DIS] = phy_host_discon;
    raw[RI_OTG_LS]   = phy_otg_ls;
    raw[RI_HOST_LS]  = phy_host_ls;
    raw[RI_OTG_CV]   = phy_otg_chg_valid;
    raw[RI_OTG_CC]   = phy_otg_chg_conn;
    raw[RI_HOST_CV]  = phy_host_chg_valid;
    raw[RI_HOST_CC]  = phy_host_chg_conn;
  end

  usbphy_sync #(.N(N_RAW)) u_sync (
    .clk(clk), .rst(rst), .async_i(raw), .sync_o(lvl), .prev_o(prv));

  // edge events
  logic [N_EVT-1:0] evt;
  always_comb begin
    evt               = '0;
    evt[EV_OTG_LS]    = lvl[RI_OTG_LS]  ^ prv[RI_OTG_LS];
    evt[EV_HOST_LS]   = lvl[RI_HOST_LS] ^ prv[RI_HOST_LS];
    evt[EV_BV_RISE]   =  lvl[RI_BVALID]   & ~prv[RI_BVALID];
    evt[EV_BV_FALL]   = ~lvl[RI_BVALID]   &  prv[RI_BVALID];
    evt[EV_ID_RISE]   =  lvl[RI_IDDIG]    & ~prv[RI_IDDIG];
    evt[EV_ID_FALL]   = ~lvl[RI_IDDIG]    &  prv[RI_IDDIG];
    evt[EV_ODIS_RISE] =  lvl[RI_OTG_DIS]  & ~prv[RI_OTG_DIS];
    evt[EV_ODIS_FALL] = ~lvl[RI_OTG_DIS]  &  prv[RI_OTG_DIS];
    evt[EV_HDIS_RISE] =  lvl[RI_HOST_DIS] & ~prv[RI_HOST_DIS];
    evt[EV_HDIS_FALL] = ~lvl[RI_HOST_DIS] &  prv[RI_HOST_DIS];
  end

  logic [N_EVT-1:0] clr_vec, sts;
  assign clr_vec = wr_clr ? (bus_wdata[N_EVT-1:0] & bus_wdata[HALF_W+N_EVT-1:HALF_W])
                          : '0;
  assign unused_wdata_hi = ^{bus_wdata[BUS_W-1:HALF_W+N_EVT], en_q[HALF_W-1:N_EVT]};

  usbphy_evt_bank #(.N(N_EVT)) u_evt (
    .clk(clk), .rst(rst), .evt_i(evt), .en_i(en_q[N_EVT-1:0]),
    .clr_i(clr_vec), .sts_o(sts), .irq_o(irq_o));

  // level word
  logic [BUS_W-1:0] lvl_word;
  always_comb begin
    lvl_word              = '0;
    lvl_word[LB_BVALID]   = lvl[RI_BVALID];
    lvl_word[LB_IDDIG]    = lvl[RI_IDDIG];
    lvl_word[LB_OTG_DIS]  = lvl[RI_OTG_DIS];
    lvl_word[LB_HOST_DIS] = lvl[RI_HOST_DIS];
    lvl_word[LB_OTG_CV]   = lvl[RI_OTG_CV];
    lvl_word[LB_OTG_CC]   = lvl[RI_OTG_CC];
    lvl_word[LB_HOST_CV]  = lvl[RI_HOST_CV];
    lvl_word[LB_HOST_CC]  = lvl[RI_HOST_CC];
  end

  // registered read mux
  logic [BUS_W-1:0] rd_d, rd_q;
  always_comb begin
    rd_d = '0;
    if (hit(word, WI_OTG_CTRL))       rd_d = BUS_W'(otg_q);
    else if (hit(word, WI_HOST_CTRL)) rd_d = BUS_W'(host_q);
    else if (hit(word, WI_CHG_CTRL))  rd_d = BUS_W'(chg_q);
    else if (hit(word, WI_LEVELS))    rd_d = lvl_word;
    else if (hit(word, WI_EVT_EN))    rd_d = BUS_W'(en_q);
    else if (hit(word, WI_EVT_STS))   rd_d = BUS_W'(sts);
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_d;
  end
  assign bus_rdata = rd_q;

  logic unmapped;
  assign unmapped = (word > WORD_W'(WI_EVT_STS));

  // R11: clear-register and unmapped reads return zero
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (rst)
    unmapped |=> (bus_rdata == '0));

  // R1/R3: the charger detectors stay in reset until software releases them
  p_chg_rst_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (otg_chg_rst_o && !wr_chg) |=> otg_chg_rst_o);
endmodule

// File: tb/usbphy_ctl_bank_tb_top.sv
module usbphy_ctl_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [9:0]  src = '0;
  logic [8:0]  otg_sus_o;
  logic [3:0]  host_sus_o;
  logic id_pullup_o, otg_clk_keep_o, host_clk_keep_o;
  logic otg_chg_en_o, otg_chg_rst_o, host_chg_en_o, host_chg_rst_o, irq_o;

  int vectors = 0;
  int fails   = 0;

  always #10 clk = ~clk;

  usbphy_ctl_bank #(.ADDR_W(5)) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .phy_bvalid(src[0]), .phy_iddig(src[1]), .phy_otg_discon(src[2]),
    .phy_host_discon(src[3]), .phy_otg_ls(src[4]), .phy_host_ls(src[5]),
    .phy_otg_chg_valid(src[6]), .phy_otg_chg_conn(src[7]),
    .phy_host_chg_valid(src[8]), .phy_host_chg_conn(src[9]),
    .otg_sus_o(otg_sus_o), .host_sus_o(host_sus_o), .id_pullup_o(id_pullup_o),
    .otg_clk_keep_o(otg_clk_keep_o), .host_clk_keep_o(host_clk_keep_o),
    .otg_chg_en_o(otg_chg_en_o), .otg_chg_rst_o(otg_chg_rst_o),
    .host_chg_en_o(host_chg_en_o), .host_chg_rst_o(host_chg_rst_o),
    .irq_o(irq_o));

  localparam logic [4:0] A_OTG = 5'h00, A_HOST = 5'h04, A_CHG = 5'h08, A_LVL = 5'h0C;
  localparam logic [4:0] A_EN = 5'h10, A_STS = 5'h14, A_CLR = 5'h18, A_NONE = 5'h1C;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int pin_of(input int b);
    if (b == 0) return 4;
    if (b == 1) return 5;
    return (b - 2) / 2;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] r, m, d, lfsr;
    logic [31:0] model [3];
    logic [15:0] impl [3];
    logic [4:0]  addr [3];
    int sel;

    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    rd(A_OTG, r);  check("R1 otg ctrl", r, 32'h1D9);
    rd(A_HOST, r); check("R1 host ctrl", r, 32'h9);
    rd(A_CHG, r);  check("R1 chg ctrl", r, 32'hA);
    rd(A_EN, r);   check("R1 enable", r, 32'h0);
    rd(A_STS, r);  check("R1 status", r, 32'h0);

    // R11 unmapped / clear register read
    rd(A_NONE, r); check("R11 unmapped", r, 32'h0);
    rd(A_CLR, r);  check("R11 clear reads 0", r, 32'h0);

    // R2/R3 masked write sweep
    model[0] = 32'h1D9; model[1] = 32'h9; model[2] = 32'hA;
    impl[0] = 16'h07FF; impl[1] = 16'h001F; impl[2] = 16'h000F;
    addr[0] = A_OTG; addr[1] = A_HOST; addr[2] = A_CHG;
    lfsr = 32'hACE1_1234;
    for (int k = 0; k < 180; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      sel = k % 3;
      d = lfsr;
      if (k % 17 == 0) d[31:16] = 16'h0;
      m = {16'h0, d[31:16]};
      wr(addr[sel], d);
      model[sel] = ((model[sel] & ~m) | ({16'h0, d[15:0]} & m)) & {16'h0, impl[sel]};
      rd(addr[sel], r);
      check("R2 masked write", r, model[sel]);
      check("R3 outputs otg", {20'b0, otg_clk_keep_o, id_pullup_o, otg_sus_o}, model[0]);
      check("R3 outputs host", {27'b0, host_clk_keep_o, host_sus_o}, model[1]);
      check("R3 outputs chg",
            {28'b0, host_chg_rst_o, host_chg_en_o, otg_chg_rst_o, otg_chg_en_o}, model[2]);
    end
    wr(A_OTG, 32'h01FF_0052);
    check("R3 otg running code", {23'b0, otg_sus_o}, 32'h052);
    wr(A_HOST, 32'h000F_0002);
    check("R3 host running code", {28'b0, host_sus_o}, 32'h2);

    // R4 level word sweep (enables all 0)
    for (int v = 0; v < 256; v++) begin
      logic [31:0] exp;
      src = '0;
      {src[9], src[8], src[7], src[6], src[3], src[2], src[1], src[0]} = v[7:0];
      idle(3);
      exp = '0;
      exp[9] = src[0]; exp[6] = src[1]; exp[7] = src[2]; exp[23] = src[3];
      exp[12] = src[6]; exp[13] = src[7]; exp[28] = src[8]; exp[29] = src[9];
      rd(A_LVL, r);
      check("R4 level word", r, exp);
    end
    rd(A_STS, r); check("R6 no status while disabled", r, 32'h0);
    check("R6 irq low while disabled", {31'b0, irq_o}, 32'h0);

    // R5/R7/R10 per-event sweep
    for (int b = 0; b < 10; b++) begin
      int p;
      logic pre;
      p = pin_of(b);
      wr(A_EN, 32'h03FF_0000);
      src = '0;
      pre = (b >= 2 && b % 2 == 1) ? 1'b1 : 1'b0;
      src[p] = pre;
      idle(4);
      wr(A_CLR, 32'h03FF_03FF);
      wr(A_EN, 32'h03FF_0000 | (32'h1 << b));
      check("R9 irq idle", {31'b0, irq_o}, 32'h0);
      src[p] = ~pre;
      idle(3);
      check("R10 irq not before edge 4", {31'b0, irq_o}, 32'h0);
      idle(1);
      check("R10 irq at edge 4", {31'b0, irq_o}, 32'h1);
      rd(A_STS, r); check("R5 event bit", r, 32'h1 << b);
      wr(A_CLR, 32'h1 << b);
      rd(A_STS, r); check("R7 unmasked clear ignored", r, 32'h1 << b);
      wr(A_STS, 32'hFFFF_FFFF);
      rd(A_STS, r); check("R7 status write ignored", r, 32'h1 << b);
      rd(A_CLR, r); check("R7 clear reads 0", r, 32'h0);
      wr(A_CLR, (32'h1 << (b + 16)) | (32'h1 << b));
      idle(1);
      check("R7 irq after clear", {31'b0, irq_o}, 32'h0);
      rd(A_STS, r); check("R7 cleared", r, 32'h0);
    end

    // R6 disabled edge while other bit enabled
    wr(A_EN, 32'h03FF_0008);
    src = '0; idle(4);
    src[0] = 1'b1; idle(5);
    rd(A_STS, r); check("R6 disabled rise", r, 32'h0);

    // R9 enable drop keeps status
    wr(A_EN, 32'h03FF_0004);
    src[0] = 1'b0; idle(4);
    src[0] = 1'b1; idle(5);
    check("R9 irq set", {31'b0, irq_o}, 32'h1);
    wr(A_EN, 32'h0004_0000);
    idle(1);
    check("R9 irq drops", {31'b0, irq_o}, 32'h0);
    rd(A_STS, r); check("R9 status kept", r, 32'h4);
    wr(A_CLR, 32'h0004_0004);

    // R8 clear and edge in the same cycle
    wr(A_EN, 32'h0004_0004);
    src[0] = 1'b0; idle(4);
    wr(A_CLR, 32'h03FF_03FF);
    src[0] = 1'b1;
    idle(2);
    wr(A_CLR, 32'h0004_0004);
    idle(1);
    rd(A_STS, r); check("R8 clear wins", r, 32'h0);
    check("R8 irq low", {31'b0, irq_o}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule